// File: doc/BRIEF.md
# Presettable Up/Down Counter Digit with Binary or Decade Modulus

This block is one synchronous counting digit of `WIDTH` bits, four by default. It counts up or down, and both the direction and the modulus are chosen at run time. The modulus is either the full binary range (16 for four bits) or a decade range of 0 to `DEC_MAX`, which defaults to 9. A load input forces the digit to a parallel value. While that input is high, the loaded value appears on the count output at once, without waiting for a clock edge.

Counting is gated by an active-low carry input. The block drives an active-low carry output, which goes low when the digit is enabled and is about to roll over. Wider counters are built by putting every digit on the same clock and wiring each digit's carry output to the carry input of the next more significant digit. The whole chain then steps on one edge, with no ripple delay between stages.

Top module: `updn_counter`

## Requirements
- R1: While `rstN` is low, `count` is 0, whatever the clock is doing.
- R2: With `loadEn` low and `carryInN` high, `count` keeps its value across clock edges.
- R3: With `binMode`=1 (binary), `upDown`=1 (up) and `carryInN` low, each rising edge adds one modulo 2^WIDTH, so 15 is followed by 0.
- R4: With `binMode`=1 and `upDown`=0 (down), each enabled edge subtracts one modulo 2^WIDTH, so 0 is followed by 15.
- R5: With `binMode`=0 (decade), counting up goes from 9 to 0, and counting down goes from 0 to 9.
- R6: In decade mode, a count from 10 to 15 becomes 0 on the next enabled up step, and drops by one on an enabled down step (10 becomes 9).
- R7: While `loadEn` is high, `count` equals `loadVal` immediately, with no clock edge needed, and counting is suppressed. After `loadEn` falls, counting continues from the `loadVal` captured at the last rising edge during the load.
- R8: `carryOutN` is low exactly when `carryInN` is low and the shown count is at its terminal value. The terminal value is 15 when counting up in binary, 9 when counting up in decade mode, and 0 when counting down in either mode. The output is combinational.
- R9: With two digits on one clock, and the low digit's `carryOutN` driving the high digit's `carryInN`, the high digit steps on exactly those edges where the low digit rolls over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared counting clock, rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| upDown | input | 1 | 1 = count up, 0 = count down |
| binMode | input | 1 | 1 = binary modulus, 0 = decade modulus |
| loadEn | input | 1 | Parallel load, active high, overrides counting |
| loadVal | input | WIDTH | Value shown and captured during a load |
| carryInN | input | 1 | Count enable, active low |
| count | output | WIDTH | Current digit value |
| carryOutN | output | 1 | Roll-over indication to the next digit, active low |

## Verification
A corrupted count register shows up on `count` at the next sample after the edge that corrupted it. The bench compares the value after every edge, so the error is caught within one cycle. A wrong terminal decode does not change this digit's value at all. It shows on `carryOutN` in the same cycle, and it shows in the next higher digit one edge later, which is why the bench checks a two-digit chain. A faulty wrap rule in decade mode appears only at 9, at 0, or when the count is out of range. The stimulus therefore starts loads just below those points.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // show and capture the parallel value
    logic step;   // advance on the next rising edge
  } ctrl_strobe_t;
endpackage

// File: rtl/updn_counter_ctrl.sv
module updn_counter_ctrl
  import updn_counter_pkg::*;
(
  input  logic         loadEn,
  input  logic         carryInN,
  input  logic         atTerminal,
  output ctrl_strobe_t strobe,
  output logic         carryOutN
);
  always_comb begin
    strobe.load = loadEn;
    strobe.step = !carryInN && !loadEn;
  end

  // Roll-over indication depends only on the enable and the shown value
  assign carryOutN = !(!carryInN && atTerminal);
endmodule

// File: rtl/updn_counter_dp.sv
module updn_counter_dp
  import updn_counter_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned DEC_MAX = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic             upDown,
  input  logic             binMode,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] shownVal,
  output logic             atTerminal
);
  localparam logic [WIDTH-1:0] BIN_TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] DEC_TOP = WIDTH'(DEC_MAX);
  localparam logic [WIDTH-1:0] ZERO    = '0;
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  logic [WIDTH-1:0] cntQ;
  logic [WIDTH-1:0] incVal;
  logic [WIDTH-1:0] decVal;
  logic [WIDTH-1:0] nextVal;
  logic [WIDTH-1:0] upTop;

  assign incVal = cntQ + ONE;
  assign decVal = cntQ - ONE;

  always_comb begin
    if (binMode) begin
      nextVal = upDown ? incVal : decVal;
    end else if (upDown) begin
      // top of the decade and any out-of-range value fold to zero
      nextVal = (cntQ >= DEC_TOP) ? ZERO : incVal;
    end else begin
      nextVal = (cntQ == ZERO) ? DEC_TOP : decVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= ZERO;
    end else if (strobe.load) begin
      cntQ <= loadVal;
    end else if (strobe.step) begin
      cntQ <= nextVal;
    end
  end

  // Load value is visible at once; register catches it on the next edge
  assign shownVal = (strobe.load && rstN) ? loadVal : cntQ;

  assign upTop      = binMode ? BIN_TOP : DEC_TOP;
  assign atTerminal = upDown ? (shownVal == upTop) : (shownVal == ZERO);
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_counter_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned DEC_MAX = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upDown,
  input  logic             binMode,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             carryInN,
  output logic [WIDTH-1:0] count,
  output logic             carryOutN
);
  ctrl_strobe_t strobe;
  logic         atTerminal;

  updn_counter_ctrl u_ctrl (
    .loadEn    (loadEn),
    .carryInN  (carryInN),
    .atTerminal(atTerminal),
    .strobe    (strobe),
    .carryOutN (carryOutN)
  );

  updn_counter_dp #(
    .WIDTH  (WIDTH),
    .DEC_MAX(DEC_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .upDown    (upDown),
    .binMode   (binMode),
    .loadVal   (loadVal),
    .shownVal  (count),
    .atTerminal(atTerminal)
  );
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned DEC_MAX = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             upDown,
  input logic             binMode,
  input logic             loadEn,
  input logic [WIDTH-1:0] loadVal,
  input logic             carryInN,
  input logic [WIDTH-1:0] count,
  input logic             carryOutN
);
  localparam logic [WIDTH-1:0] DEC_TOP = WIDTH'(DEC_MAX);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (carryInN && !loadEn) |=> (loadEn || count == $past(count)));

  // R3
  bin_up_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!carryInN && !loadEn && upDown && binMode)
      |=> (loadEn || count == WIDTH'($past(count) + 1'b1)));

  // R4
  bin_down_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!carryInN && !loadEn && !upDown && binMode)
      |=> (loadEn || count == WIDTH'($past(count) - 1'b1)));

  // R5
  dec_stays_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!carryInN && !loadEn && !binMode && count <= DEC_TOP)
      |=> (loadEn || count <= DEC_TOP));

  // R7
  load_shows_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> count == loadVal);

  // R8
  carry_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !carryOutN |-> !carryInN);
endmodule

bind updn_counter updn_counter_chk #(
  .WIDTH  (WIDTH),
  .DEC_MAX(DEC_MAX)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .upDown   (upDown),
  .binMode  (binMode),
  .loadEn   (loadEn),
  .loadVal  (loadVal),
  .carryInN (carryInN),
  .count    (count),
  .carryOutN(carryOutN)
);

// File: tb/updn_counter_bench.sv
module updn_counter_bench;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] loCnt;
    logic         loCo;
    logic [W-1:0] hiCnt;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upDown = 1'b1;
  logic binMode = 1'b1;
  logic loadEn = 1'b0;
  logic [W-1:0] loadVal = '0;
  logic carryInN = 1'b1;
  logic [W-1:0] loCount, hiCount;
  logic loCarryN, hiCarryN;

  int checks = 0;
  int fails = 0;
  exp_t expQ[$];
  logic [W-1:0] loModel = '0;
  logic [W-1:0] hiModel = '0;

  always #10 clk = ~clk;

  updn_counter u_updn_counter (
    .clk(clk), .rstN(rstN), .upDown(upDown), .binMode(binMode),
    .loadEn(loadEn), .loadVal(loadVal), .carryInN(carryInN),
    .count(loCount), .carryOutN(loCarryN)
  );

  updn_counter u_updn_counter_hi (
    .clk(clk), .rstN(rstN), .upDown(upDown), .binMode(binMode),
    .loadEn(loadEn), .loadVal(loadVal), .carryInN(loCarryN),
    .count(hiCount), .carryOutN(hiCarryN)
  );

  function automatic logic [W-1:0] nextOf(logic [W-1:0] v, logic up, logic bin);
    if (bin) return up ? W'(v + 1) : W'(v - 1);
    if (up) return (v >= 9) ? '0 : W'(v + 1);
    return (v == 0) ? W'(9) : W'(v - 1);
  endfunction

  function automatic logic carryOf(logic [W-1:0] v, logic up, logic bin, logic cinN);
    logic term;
    term = up ? (v == (bin ? W'(15) : W'(9))) : (v == 0);
    return !(!cinN && term);
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Driver: apply one cycle of inputs, push the expected result
  task automatic drive(logic up, logic bin, logic ld, logic [W-1:0] val,
                       logic cinN, string tag);
    exp_t e;
    logic loCoPre;
    @(negedge clk);
    upDown = up; binMode = bin; loadEn = ld; loadVal = val; carryInN = cinN;
    if (ld) begin
      loModel = val;
      hiModel = val;
    end else begin
      loCoPre = carryOf(loModel, up, bin, cinN);
      if (!cinN) loModel = nextOf(loModel, up, bin);
      if (!loCoPre) hiModel = nextOf(hiModel, up, bin);
    end
    e.loCnt = loModel;
    e.loCo  = ld ? carryOf(val, up, bin, cinN) : carryOf(loModel, up, bin, cinN);
    e.hiCnt = hiModel;
    e.tag   = tag;
    expQ.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " low count"}, loCount, e.loCnt);
        check({e.tag, " low carry"}, loCarryN, e.loCo);
        check({e.tag, " high count"}, hiCount, e.hiCnt);
      end
    end
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: clear while reset held, clock running
    #55;
    check("R1 reset count", loCount, 0);
    check("R1 reset carry", loCarryN, 1);
    @(negedge clk);
    rstN = 1'b1;

    // R7: load shows at once, mid-cycle
    @(negedge clk);
    loadEn = 1'b1; loadVal = 4'd13;
    #3;
    check("R7 immediate load", loCount, 13);
    drive(1, 1, 1, 4'd13, 1, "R7 load");
    // R3 binary up through 15 -> 0, R8 carry at 15, R9 high digit steps
    drive(1, 1, 0, 4'd0, 0, "R3 up");
    drive(1, 1, 0, 4'd0, 0, "R3 R8 up to 15");
    drive(1, 1, 0, 4'd0, 0, "R3 R9 wrap");
    drive(1, 1, 0, 4'd0, 0, "R3 up");
    // R2 hold
    drive(1, 1, 0, 4'd0, 1, "R2 hold");
    drive(1, 1, 0, 4'd0, 1, "R2 hold");
    // R4 binary down through 0
    drive(0, 1, 0, 4'd0, 0, "R4 R8 down to 0");
    drive(0, 1, 0, 4'd0, 0, "R4 R9 wrap");
    drive(0, 1, 0, 4'd0, 0, "R4 down");
    // R5 decade up
    drive(1, 0, 1, 4'd7, 0, "R7 load overrides");
    drive(1, 0, 0, 4'd0, 0, "R5 up");
    drive(1, 0, 0, 4'd0, 0, "R5 R8 up to 9");
    drive(1, 0, 0, 4'd0, 0, "R5 R9 wrap");
    // R5 decade down
    drive(0, 0, 1, 4'd1, 0, "R7 load");
    drive(0, 0, 0, 4'd0, 0, "R5 R8 down to 0");
    drive(0, 0, 0, 4'd0, 0, "R5 R9 wrap");
    // R6 out-of-range decade values
    drive(0, 0, 1, 4'd11, 0, "R7 load");
    drive(0, 0, 0, 4'd0, 0, "R6 down");
    drive(0, 0, 0, 4'd0, 0, "R6 down to 9");
    drive(1, 0, 1, 4'd14, 0, "R7 load");
    drive(1, 0, 0, 4'd0, 0, "R6 up to 0");
    drive(1, 0, 0, 4'd0, 0, "R6 up");
    // R9 longer chain run in decade
    for (int i = 0; i < 12; i++) drive(1, 0, 0, 4'd0, 0, "R9 chain");
    // R1 asynchronous reset mid-cycle
    @(negedge clk);
    carryInN = 1'b1;
    #3;
    rstN = 1'b0;
    #2;
    check("R1 async clear", loCount, 0);
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule